// File: doc/BRIEF.md
# Video ancillary packet flag generator

This block watches two 10-bit video word streams, one word of each per pixel clock, and raises a flag for every word that belongs to an embedded ancillary data packet. A packet starts with the three-word start sequence 000h, 3FFh, 3FFh. Three header words follow: a packet identifier, a secondary identifier or block number, and a data count. After these come as many user words as the data count gives, and then one checksum word. The block parses the data count, so each flag covers exactly the words from the first start word through the checksum and no more.

A mode input selects how the two word inputs are read and how the two flags are driven. In HD, SD demultiplexed and 3G Level A modes, each word input is parsed on its own and owns one flag. In 3G Level B mode, the two links are interleaved clock by clock. Each link gets its own flag, and that flag covers packets on either word input of the link. The multiplexed 10-bit formats hold one or both flags low. The flags are registered, so downstream logic can use them directly as clock enables or FIFO write enables. A separate valid output tells that logic when the flags are to be trusted.

Top module: `anc_flag_gen`

## Requirements
- R1: A flag is high for every word of a packet, from the 000h start word through the checksum word, and low for all other words. Each flag lags the word it describes by exactly 5 clocks.
- R2: The number of user words is the low 8 bits of the data count word, and the upper 2 bits are ignored. A count of 0 puts the checksum directly after the data count. A count of 255 is covered in full.
- R3: Only the three consecutive words 000h, 3FFh, 3FFh start a packet. Partial or reordered sequences flag nothing. When repeated 000h words come before a start sequence, only the last 000h is flagged.
- R4: A start sequence inside a packet being counted is ignored. A start sequence that begins on the word right after a checksum is recognised.
- R5: Mode is encoded 0 HD, 1 SD demultiplexed, 2 SD multiplexed, 3 3G Level A, 4 3G Level B, 5 3G multiplexed, with 6 and 7 unused. In modes 0, 1 and 3, flag_a marks packets on word_a and flag_b marks packets on word_b, independently of each other.
- R6: In mode 4, clocks alternate between link 1 and link 2, and the first clock after reset is a link 1 clock. flag_a is high only on link 1 clocks inside a link 1 packet carried on word_a or word_b. flag_b does the same for link 2.
- R7: In mode 2, flag_a marks packets on word_a. flag_b stays low whatever word_b carries.
- R8: In mode 5 and in the unused codes 6 and 7, both flags stay low.
- R9: flags_valid equals proc_en delayed by one clock.
- R10: While rst_n is low, flag_a, flag_b and flags_valid are low, and the link phase returns to link 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_en | input | 1 | Processing enable; low marks the flags as invalid |
| mode | input | 3 | Video mode and multiplexing format select |
| word_a | input | 10 | Luma, link 1, or multiplexed word stream |
| word_b | input | 10 | Chroma or link 2 word stream |
| flag_a | output | 1 | Packet flag for stream or link 1 |
| flag_b | output | 1 | Packet flag for stream or link 2 |
| flags_valid | output | 1 | Flags can be trusted |

## Verification
The hardest case to reach is 3G Level B. There, a start sequence exists only in every other word, and the flag for one link must come from either input while staying low on the other link's clocks. The stimulus places packet words at a stride of two, with an offset that follows the link phase known from reset, and puts one link's packet on word_b so that it must show up on flag_a. Two further cases come from dedicated streams. One hides a complete start sequence inside a packet's user words and follows that packet at once with another. The other drives a data count of 2FFh, which spans 255 user words.

// File: rtl/anc_flag_gen_pkg.sv
package anc_flag_gen_pkg;

  // mode codes
  localparam logic [2:0] MODE_HD       = 3'd0;
  localparam logic [2:0] MODE_SD_DEMUX = 3'd1;
  localparam logic [2:0] MODE_SD_MUX   = 3'd2;
  localparam logic [2:0] MODE_3G_A     = 3'd3;
  localparam logic [2:0] MODE_3G_B     = 3'd4;
  localparam logic [2:0] MODE_3G_MUX   = 3'd5;

  // packet parser position, one value per word kind after the start sequence
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_SUBID,
    ST_COUNT,
    ST_USER,
    ST_CHECK
  } pkt_stage_e;

  // word-to-flag latency seen at the ports
  localparam int FLAG_LATENCY = 5;
  // a parser mark trails its word by 2 enabled steps; the output register adds one
  localparam int MARK_LAG     = 2;
  // extra stages that bring non-interleaved marks to the interleaved latency
  localparam int ALIGN_STAGES = FLAG_LATENCY - 1 - MARK_LAG;

  function automatic logic is_interleaved(input logic [2:0] m);
    return m == MODE_3G_B;
  endfunction

endpackage

// File: rtl/anc_pkt_parser.sv
module anc_pkt_parser
  import anc_flag_gen_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  output logic              mark,
  output logic              det
);

  localparam logic [WORD_W-1:0] W_ZERO  = '0;
  localparam logic [WORD_W-1:0] W_ONES  = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

  // length of the start-sequence prefix matched so far (0, 1 or 2 words)
  function automatic logic [1:0] prefix_step(input logic [1:0] p, input logic [WORD_W-1:0] w);
    if (w == W_ZERO)             return 2'd1;
    if (w == W_ONES && p == 2'd1) return 2'd2;
    return 2'd0;
  endfunction

  logic [1:0]       pre_q;
  pkt_stage_e       st_q;
  logic [CNT_W-1:0] left_q;
  logic             r0_q, r1_q;
  logic             in_pkt;
  logic [CNT_W-1:0] count_field;

  assign count_field = word[CNT_W-1:0];
  assign det    = en && (st_q == ST_IDLE) && (pre_q == 2'd2) && (word == W_ONES);
  assign in_pkt = det || (st_q != ST_IDLE);
  // r1_q describes the word two enabled steps back; det back-fills the start words
  assign mark   = en && (r1_q || det);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= 2'd0;
      st_q   <= ST_IDLE;
      left_q <= '0;
      r0_q   <= 1'b0;
      r1_q   <= 1'b0;
    end else if (en) begin
      r0_q  <= in_pkt;
      r1_q  <= r0_q || det;
      pre_q <= (st_q == ST_IDLE && !det) ? prefix_step(pre_q, word) : 2'd0;
      unique case (st_q)
        ST_IDLE:  if (det) st_q <= ST_ID;
        ST_ID:    st_q <= ST_SUBID;
        ST_SUBID: st_q <= ST_COUNT;
        ST_COUNT: begin
          left_q <= count_field;
          st_q   <= (count_field == '0) ? ST_CHECK : ST_USER;
        end
        ST_USER: begin
          left_q <= left_q - CNT_ONE;
          if (left_q == CNT_ONE) st_q <= ST_CHECK;
        end
        ST_CHECK: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/anc_flag_route.sv
module anc_flag_route
  import anc_flag_gen_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       phase,
  input  logic       nrm_a,
  input  logic       nrm_b,
  input  logic       link1,
  input  logic       link2,
  output logic       out_a,
  output logic       out_b
);

  always_comb begin
    out_a = 1'b0;
    out_b = 1'b0;
    case (mode)
      MODE_HD, MODE_SD_DEMUX, MODE_3G_A: begin
        out_a = nrm_a;
        out_b = nrm_b;
      end
      MODE_SD_MUX: out_a = nrm_a;
      MODE_3G_B: begin
        out_a = link1 && !phase;
        out_b = link2 && phase;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/anc_flag_gen.sv
module anc_flag_gen
  import anc_flag_gen_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_en,
  input  logic [2:0]        mode,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic              flag_a,
  output logic              flag_b,
  output logic              flags_valid
);

  localparam int N_PARSERS = 4;

  logic                    phase;   // 0: link 1 clock, 1: link 2 clock
  logic                    en_lo, en_hi;
  logic [N_PARSERS-1:0]    pmark, pdet;
  logic [ALIGN_STAGES-1:0] dly_a, dly_b;
  logic                    nxt_a, nxt_b;

  assign en_lo = is_interleaved(mode) ? !phase : 1'b1;
  assign en_hi = is_interleaved(mode) ?  phase : 1'b0;

  // parser gi: bit 0 picks the word input, bit 1 picks the link slot
  for (genvar gi = 0; gi < N_PARSERS; gi++) begin : g_par
    anc_pkt_parser #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_par (
      .clk  (clk),
      .rst_n(rst_n),
      .en   ((gi >= 2) ? en_hi : en_lo),
      .word ((gi % 2 == 1) ? word_b : word_a),
      .mark (pmark[gi]),
      .det  (pdet[gi])
    );
  end

  anc_flag_route u_route (
    .mode (mode),
    .phase(phase),
    .nrm_a(dly_a[ALIGN_STAGES-1]),
    .nrm_b(dly_b[ALIGN_STAGES-1]),
    .link1(pmark[0] || pmark[1]),
    .link2(pmark[2] || pmark[3]),
    .out_a(nxt_a),
    .out_b(nxt_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= 1'b0;
      dly_a       <= '0;
      dly_b       <= '0;
      flag_a      <= 1'b0;
      flag_b      <= 1'b0;
      flags_valid <= 1'b0;
    end else begin
      phase    <= !phase;
      dly_a[0] <= pmark[0];
      dly_b[0] <= pmark[1];
      for (int i = 1; i < ALIGN_STAGES; i++) begin
        dly_a[i] <= dly_a[i-1];
        dly_b[i] <= dly_b[i-1];
      end
      flag_a      <= nxt_a;
      flag_b      <= nxt_b;
      flags_valid <= proc_en;
    end
  end

endmodule

// File: rtl/anc_flag_gen_chk.sv
module anc_flag_gen_chk
  import anc_flag_gen_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_en,
  input logic [2:0]        mode,
  input logic [WORD_W-1:0] word_a,
  input logic              flag_a,
  input logic              flag_b,
  input logic              flags_valid,
  input logic              phase,
  input logic [3:0]        pdet
);

  localparam logic [WORD_W-1:0] C_ZERO = '0;
  localparam logic [WORD_W-1:0] C_ONES = '1;

  p_sd_mux_b_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_SD_MUX) |-> !flag_b);

  p_mux3g_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_3G_MUX || $past(mode) > 3'd5) |-> (!flag_a && !flag_b));

  p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(proc_en) |-> !flags_valid);

  p_link2_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_3G_B && $past(phase)) |-> !flag_a);

  p_link1_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_3G_B && !$past(phase)) |-> !flag_b);

  p_start_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_3G_B && pdet[0]) |-> ($past(word_a) == C_ONES && $past(word_a, 2) == C_ZERO));

endmodule

bind anc_flag_gen anc_flag_gen_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .proc_en    (proc_en),
  .mode       (mode),
  .word_a     (word_a),
  .flag_a     (flag_a),
  .flag_b     (flag_b),
  .flags_valid(flags_valid),
  .phase      (phase),
  .pdet       (pdet)
);

// File: tb/anc_flag_gen_tb.sv
module anc_flag_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL       = 320;
  localparam logic [9:0] IDLE_W = 10'h040;
  localparam int NV = 8;
  // mode, a_start, a_count, a_link, b_start, b_count, b_link (start is a slot in mode 4)
  localparam int TV [NV][7] = '{
    '{0, 2, 3, 0, 9, 0, 0},
    '{1, 4, 5, 0, 4, 2, 0},
    '{2, 3, 4, 0, 3, 4, 0},
    '{3, 0, 1, 0, 5, 6, 0},
    '{4, 1, 2, 0, 3, 3, 1},
    '{4, 2, 1, 1, 0, 2, 0},
    '{5, 1, 3, 0, 2, 3, 0},
    '{6, 1, 2, 0, 1, 2, 0}
  };

  logic       clk, rst_n, proc_en;
  logic [2:0] mode;
  logic [9:0] word_a, word_b;
  logic       flag_a, flag_b, flags_valid;

  anc_flag_gen u_dut (
    .clk(clk), .rst_n(rst_n), .proc_en(proc_en), .mode(mode),
    .word_a(word_a), .word_b(word_b),
    .flag_a(flag_a), .flag_b(flag_b), .flags_valid(flags_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nerr = 0;
  bit done = 0;
  logic [9:0] wa [MAXL];
  logic [9:0] wb [MAXL];
  bit ra [MAXL];
  bit rb [MAXL];
  int len;

  task automatic check(input logic act, input logic exp, input string req, input string what, input int idx);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s word %0d: actual %b expected %b", req, what, idx, act, exp);
    end
  endtask

  task automatic clear_streams();
    for (int i = 0; i < MAXL; i++) begin
      wa[i] = IDLE_W; wb[i] = IDLE_W; ra[i] = 0; rb[i] = 0;
    end
    len = 0;
  endtask

  // one packet: start words, id, sub id, count, user words, checksum (R1, R2)
  task automatic place(input bit on_b, input int start, input int step, input logic [9:0] dc, input bit nested);
    int n;
    n = int'(dc[7:0]);
    for (int i = 0; i < n + 7; i++) begin
      int pos;
      logic [9:0] w;
      pos = start + i * step;
      if (i == 0)               w = 10'h000;
      else if (i < 3)           w = 10'h3FF;
      else if (i == 3)          w = 10'h141;
      else if (i == 4)          w = 10'h105;
      else if (i == 5)          w = dc;
      else if (i == n + 6)      w = 10'h1A5;
      else if (nested && i < 9) w = (i == 6) ? 10'h000 : 10'h3FF;
      else                      w = 10'h200 + 10'(i % 256);
      if (on_b) begin wb[pos] = w; rb[pos] = 1; end
      else      begin wa[pos] = w; ra[pos] = 1; end
      if (pos + 1 > len) len = pos + 1;
    end
  endtask

  function automatic bit exp_a(input int m, input int p);
    case (m)
      0, 1, 2, 3: return ra[p];
      4:          return (p % 2 == 0) && (ra[p] || rb[p]);
      default:    return 0;
    endcase
  endfunction

  function automatic bit exp_b(input int m, input int p);
    case (m)
      0, 1, 3: return rb[p];
      4:       return (p % 2 == 1) && (ra[p] || rb[p]);
      default: return 0;
    endcase
  endfunction

  function automatic string tag(input int m);
    case (m)
      4:       return "R1 R6";
      2:       return "R1 R7";
      5, 6, 7: return "R8";
      default: return "R1 R5";
    endcase
  endfunction

  task automatic run(input int m, input string req);
    mode = 3'(m); rst_n = 0; proc_en = 1; word_a = IDLE_W; word_b = IDLE_W;
    repeat (3) @(negedge clk);
    check(flag_a, 1'b0, "R10", "flag_a in reset", 0);
    check(flag_b, 1'b0, "R10", "flag_b in reset", 0);
    check(flags_valid, 1'b0, "R10", "flags_valid in reset", 0);
    rst_n = 1;
    for (int p = 0; p < len + 6; p++) begin
      if (p > 0) @(negedge clk);
      if (p >= 5) begin
        check(flag_a, exp_a(m, p - 5), req, "flag_a", p - 5);
        check(flag_b, exp_b(m, p - 5), req, "flag_b", p - 5);
      end
      if (p == 1) check(flags_valid, 1'b1, "R9", "flags_valid", p);
      word_a = (p < len) ? wa[p] : IDLE_W;
      word_b = (p < len) ? wb[p] : IDLE_W;
    end
  endtask

  initial begin
    rst_n = 0; proc_en = 1; mode = 3'd0; word_a = IDLE_W; word_b = IDLE_W;

    for (int v = 0; v < NV; v++) begin
      int m, stp;
      clear_streams();
      m   = TV[v][0];
      stp = (m == 4) ? 2 : 1;
      place(0, (m == 4) ? 2 * TV[v][1] + TV[v][3] : TV[v][1], stp, 10'(TV[v][2]) | 10'h200, 0);
      place(1, (m == 4) ? 2 * TV[v][4] + TV[v][6] : TV[v][4], stp, 10'(TV[v][5]) | 10'h200, 0);
      run(m, tag(m));
    end

    // R2: zero count on both streams, upper count bits differ
    clear_streams();
    place(0, 2, 1, 10'h000, 0);
    place(1, 2, 1, 10'h100, 0);
    run(0, "R2");

    // R2: count field 2FFh means 255 user words
    clear_streams();
    place(0, 1, 1, 10'h2FF, 0);
    run(0, "R2");

    // R3: broken start sequences, repeated 000h before a real start
    clear_streams();
    wa[1] = 10'h000; wa[2] = 10'h3FF; wa[3] = IDLE_W; wa[4] = 10'h3FF; wa[5] = 10'h3FF;
    wa[6] = 10'h000; wa[7] = 10'h000;
    place(0, 8, 1, 10'h202, 0);
    wb[1] = 10'h3FF; wb[2] = 10'h3FF; wb[3] = 10'h3FF; wb[4] = 10'h000; wb[5] = 10'h3FF;
    wb[6] = 10'h200;
    run(0, "R3");

    // R4: start sequence hidden in user words, then a packet right after the checksum
    clear_streams();
    place(0, 1, 1, 10'h206, 1);
    place(0, 14, 1, 10'h201, 0);
    place(1, 3, 1, 10'h203, 1);
    run(0, "R4");

    // R9: valid follows proc_en by one clock
    @(negedge clk);
    proc_en = 0;
    @(negedge clk);
    check(flags_valid, 1'b0, "R9", "flags_valid after drop", 0);
    proc_en = 1;
    @(negedge clk);
    check(flags_valid, 1'b1, "R9", "flags_valid after restore", 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule